// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Idle Timeout

This block sits between the receive character router of a UART and the host-visible data register. Each received byte is pushed into a 16-entry byte queue. The host takes bytes out by reading the data register, which the register block signals as a one-cycle read strobe. The block tracks its fill level and keeps three registered status flags: empty, full and trigger. The trigger flag compares the fill level against a programmable threshold. The block also produces two one-cycle event pulses for the interrupt logic. One marks a byte lost to a full queue. The other marks an idle gap in the incoming stream.

The idle gap is measured in character times. A character time is the configured bit period in clock cycles multiplied by the frame length. The frame length is one start bit, plus the data width (6, 7 or 8), plus an optional parity bit, plus one or two stop bits. Each byte the queue accepts restarts a countdown of four character times. If the countdown runs out before another byte arrives, the timeout pulse fires. A receive reset request empties the queue, clears the flags and stops the countdown.

Top module: `uart_rxq_top`

## Requirements
- R1: After reset the queue is empty (empty=1, full=0, trigger=0, read data 0), and the trigger threshold is 0x20. Because 0x20 is above the depth, the trigger flag stays low even with all 16 entries stored until the threshold is rewritten.
- R2: Bytes come out in the order they were accepted. The byte for a read strobe sampled at a clock edge appears on `rd_data` right after that edge and holds until the next read strobe.
- R3: A push while 16 entries are stored and no read is taken in the same cycle stores nothing and leaves the contents unchanged. It produces a one-cycle `overrun` pulse in the cycle after the push.
- R4: A push and an enabled read in the same cycle while the queue is full perform the read first and store the pushed byte. No overrun occurs and full stays set.
- R5: An enabled read of an empty queue returns 0 and leaves empty set.
- R6: A read strobe while `rx_en` is low removes nothing and changes no flag. It returns 0 on `rd_data`.
- R7: On every push or enabled read, the trigger flag is set if the resulting count is greater than or equal to the threshold, and cleared otherwise. Writing the threshold alone does not change the flag.
- R8: A receive reset request (`flush`) empties the queue and clears full and trigger. It cancels a pending timeout. It wins over a push in the same cycle.
- R9: The full flag is set exactly when 16 entries are stored, and any enabled read that is not matched by a push clears it. The empty flag clears on any accepted push.
- R10: `timeout` pulses for one cycle exactly 4 × character-time cycles after the clock edge that accepted the most recent byte, and each accepted byte restarts the wait. Character time is `bit_cycles` × (1 + data bits + `parity_en` + (`two_stop` ? 2 : 1)). The data bits are selected by `char_len`: 2'b00 = 6, 2'b01 = 7, 2'b10 or 2'b11 = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive path enabled; gates host reads |
| flush | input | 1 | Receive reset request |
| push_valid | input | 1 | A received byte is offered this cycle |
| push_data | input | 8 | Received byte |
| rd_strobe | input | 1 | Host read of the data register |
| lvl_we | input | 1 | Write enable for the trigger threshold |
| lvl_wdata | input | 6 | New trigger threshold |
| bit_cycles | input | 16 | Clock cycles per serial bit |
| char_len | input | 2 | Data width select (00=6, 01=7, 1x=8) |
| parity_en | input | 1 | Frame carries a parity bit |
| two_stop | input | 1 | Frame carries two stop bits |
| rd_data | output | 8 | Byte returned by the last read strobe |
| empty | output | 1 | Queue holds no bytes |
| full | output | 1 | Queue holds 16 bytes |
| trig | output | 1 | Fill level at or above threshold |
| overrun | output | 1 | One-cycle pulse: byte lost to a full queue |
| timeout | output | 1 | One-cycle pulse: idle gap of four character times |

## Verification
The bench fills the queue to the brim and then pushes once more. A design that wraps its write pointer would overwrite the oldest byte, and the drained sequence would show the extra value. It then pushes and reads at the same time on a full queue. A design that checks space before applying the read would flag an overrun and lose the byte. The timeout is timed to the exact cycle under three frame formats and across a restart, so an off-by-one in the countdown or a wrong frame length shows as an early or late pulse. Reads with the receive path disabled, reads of an empty queue, and a flush that coincides with a push are each checked through the following reads. These catch a design that drops data, returns stale bytes or keeps a cancelled timer running.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    LEN6  = 2'b00,
    LEN7  = 2'b01,
    LEN8  = 2'b10,
    LEN8X = 2'b11
  } char_len_e;

  // Serial frame length in bits: start + data + optional parity + stop bits.
  function automatic logic [3:0] frame_bits(char_len_e len, logic par, logic two);
    logic [3:0] data_n;
    case (len)
      LEN6:    data_n = 4'd6;
      LEN7:    data_n = 4'd7;
      default: data_n = 4'd8;
    endcase
    return 4'd1 + data_n + {3'b000, par} + (two ? 4'd2 : 4'd1);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_any,
  input  logic              rd_en,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    count_next = count;
    if (flush) begin
      count_next = '0;
    end else begin
      if (wr_en && !rd_en) count_next = count + 1'b1;
      if (rd_en && !wr_en) count_next = count - 1'b1;
    end
  end

  // Storage array without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_any && !flush) begin
      rd_data <= rd_en ? mem[rptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= bump(wptr);
      if (rd_en) rptr <= bump(rptr);
      count <= count_next;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !wr_en && !flush) |=> (count == '0));

endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             evt,
  input  logic [CNT_W-1:0] count_next,
  input  logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             trig
);

  logic [LVL_W-1:0] cnt_ext;
  assign cnt_ext = LVL_W'(count_next);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      empty <= 1'b1;
      full  <= 1'b0;
      trig  <= 1'b0;
    end else if (evt) begin
      empty <= (count_next == '0);
      full  <= (count_next == CNT_W'(DEPTH));
      trig  <= (cnt_ext >= level);
    end
  end

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({empty, full}));

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout
  import uart_rxq_pkg::*;
#(
  parameter int BIT_W = 16,
  localparam int CHR_W = BIT_W + 4,
  localparam int TMR_W = BIT_W + 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cancel,
  input  logic             restart,
  input  logic [BIT_W-1:0] bit_cycles,
  input  logic [1:0]       char_len,
  input  logic             parity_en,
  input  logic             two_stop,
  output logic             fire
);

  logic [3:0]       frame;
  logic [CHR_W-1:0] char_cyc;
  logic [TMR_W-1:0] window;
  logic [TMR_W-1:0] remain;

  assign frame    = frame_bits(char_len_e'(char_len), parity_en, two_stop);
  assign char_cyc = CHR_W'(bit_cycles) * CHR_W'(frame);
  assign window   = {char_cyc, 2'b00};

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      remain <= '0;
      fire   <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (restart) begin
        remain <= window;
      end else if (remain != '0) begin
        remain <= remain - 1'b1;
        if (remain == TMR_W'(1)) fire <= 1'b1;
      end
    end
  end

  // R8
  cancel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cancel |=> (remain == '0 && !fire));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 16,
  parameter int BIT_W     = 16,
  parameter int LVL_RESET = 32,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int LVL_W    = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              flush,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              rd_strobe,
  input  logic              lvl_we,
  input  logic [LVL_W-1:0]  lvl_wdata,
  input  logic [BIT_W-1:0]  bit_cycles,
  input  logic [1:0]        char_len,
  input  logic              parity_en,
  input  logic              two_stop,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              trig,
  output logic              overrun,
  output logic              timeout
);

  logic [CNT_W-1:0] count, count_next;
  logic [LVL_W-1:0] level;
  logic             rd_ok, pop_en, push_ok, evt;

  assign rd_ok   = rd_strobe && rx_en && !flush;
  assign pop_en  = rd_ok && (count != '0);
  // The read is applied first, so a full queue with a pop has room.
  assign push_ok = push_valid && !flush && ((count != CNT_W'(DEPTH)) || pop_en);
  assign evt     = push_ok || rd_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= LVL_W'(LVL_RESET);
      overrun <= 1'b0;
    end else begin
      if (lvl_we) level <= lvl_wdata;
      overrun <= push_valid && !flush && !push_ok;
    end
  end

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .wr_en      (push_ok),
    .wr_data    (push_data),
    .rd_any     (rd_strobe),
    .rd_en      (pop_en),
    .count      (count),
    .count_next (count_next),
    .rd_data    (rd_data)
  );

  rxq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_status (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .evt        (evt),
    .count_next (count_next),
    .level      (level),
    .empty      (empty),
    .full       (full),
    .trig       (trig)
  );

  rxq_timeout #(.BIT_W(BIT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .cancel     (flush),
    .restart    (push_ok),
    .bit_cycles (bit_cycles),
    .char_len   (char_len),
    .parity_en  (parity_en),
    .two_stop   (two_stop),
    .fire       (timeout)
  );

  // R3
  overrun_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !flush && count == CNT_W'(DEPTH) && !pop_en)
      |=> (overrun && count == CNT_W'(DEPTH)));

  // R4
  pop_first_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !flush && rd_strobe && rx_en && count == CNT_W'(DEPTH))
      |=> (!overrun && count == CNT_W'(DEPTH)));

  // R9
  full_match_chk: assert property (@(posedge clk) disable iff (rst)
    full == (count == CNT_W'(DEPTH)));

  // R9
  empty_match_chk: assert property (@(posedge clk) disable iff (rst)
    empty == (count == '0));

  // R6
  rd_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !rx_en && !push_valid && !flush) |=> $stable(count));

endmodule

// File: tb/uart_rxq_top_tb.sv
`timescale 1ns/1ps
module uart_rxq_top_tb;

  logic       clk = 1'b0;
  logic       rst, rx_en, flush, push_valid, rd_strobe, lvl_we;
  logic [7:0] push_data;
  logic [5:0] lvl_wdata;
  logic [15:0] bit_cycles;
  logic [1:0] char_len;
  logic       parity_en, two_stop;
  logic [7:0] rd_data;
  logic       empty, full, trig, overrun, timeout;

  int n_total = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  uart_rxq_top u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .flush(flush),
    .push_valid(push_valid), .push_data(push_data), .rd_strobe(rd_strobe),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .bit_cycles(bit_cycles),
    .char_len(char_len), .parity_en(parity_en), .two_stop(two_stop),
    .rd_data(rd_data), .empty(empty), .full(full), .trig(trig),
    .overrun(overrun), .timeout(timeout)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(logic [7:0] b);
    push_valid = 1'b1; push_data = b;
    tick();
    push_valid = 1'b0;
  endtask

  task automatic pop();
    rd_strobe = 1'b1;
    tick();
    rd_strobe = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    tick();
    flush = 1'b0;
  endtask

  task automatic set_level(logic [5:0] v);
    lvl_we = 1'b1; lvl_wdata = v;
    tick();
    lvl_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 trig", trig, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_order();
    logic [7:0] v[5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    do_flush();
    foreach (v[i]) push(v[i]);
    chk("R9 empty cleared", empty, 0);
    foreach (v[i]) begin
      pop();
      chk("R2 order", rd_data, v[i]);
    end
    chk("R9 empty after drain", empty, 1);
  endtask

  task automatic t_overrun();
    do_flush();
    for (int i = 0; i < 16; i++) push(8'(i * 3 + 1));
    chk("R9 full set", full, 1);
    chk("R1 trig at 16 with default level", trig, 0);
    push_valid = 1'b1; push_data = 8'hEE;
    tick();
    push_valid = 1'b0;
    chk("R3 overrun pulse", overrun, 1);
    tick();
    chk("R3 overrun one cycle", overrun, 0);
    pop();
    chk("R9 full cleared by read", full, 0);
    chk("R3 first byte", rd_data, 8'h01);
    for (int i = 1; i < 16; i++) begin
      pop();
      chk("R3 contents kept", rd_data, 8'(i * 3 + 1));
    end
    chk("R3 extra byte not stored", empty, 1);
  endtask

  task automatic t_simul();
    do_flush();
    for (int i = 0; i < 16; i++) push(8'(8'h80 + i));
    push_valid = 1'b1; push_data = 8'hAB; rd_strobe = 1'b1;
    tick();
    push_valid = 1'b0; rd_strobe = 1'b0;
    chk("R4 read data", rd_data, 8'h80);
    chk("R4 no overrun", overrun, 0);
    chk("R4 full kept", full, 1);
    for (int i = 1; i < 16; i++) pop();
    chk("R4 last old byte", rd_data, 8'h8F);
    pop();
    chk("R4 pushed byte stored", rd_data, 8'hAB);
    chk("R4 empty after drain", empty, 1);
  endtask

  task automatic t_empty_read();
    do_flush();
    push(8'h77);
    pop();
    chk("R5 setup byte", rd_data, 8'h77);
    pop();
    chk("R5 zero on empty", rd_data, 0);
    chk("R5 empty kept", empty, 1);
  endtask

  task automatic t_disabled();
    do_flush();
    push(8'h5A);
    rx_en = 1'b0;
    pop();
    chk("R6 zero when disabled", rd_data, 0);
    chk("R6 empty unchanged", empty, 0);
    rx_en = 1'b1;
    pop();
    chk("R6 byte still there", rd_data, 8'h5A);
  endtask

  task automatic t_trigger();
    do_flush();
    set_level(6'd4);
    for (int i = 0; i < 3; i++) push(8'(i));
    chk("R7 below level", trig, 0);
    push(8'h03);
    chk("R7 at level", trig, 1);
    pop();
    chk("R7 cleared below level", trig, 0);
    set_level(6'd2);
    chk("R7 level write alone", trig, 0);
    push(8'h04);
    chk("R7 set on next push", trig, 1);
    set_level(6'd32);
    do_flush();
  endtask

  task automatic t_flush();
    do_flush();
    for (int i = 0; i < 16; i++) push(8'(i));
    flush = 1'b1; push_valid = 1'b1; push_data = 8'hC3;
    tick();
    flush = 1'b0; push_valid = 1'b0;
    chk("R8 empty", empty, 1);
    chk("R8 full cleared", full, 0);
    pop();
    chk("R8 push lost to flush", rd_data, 0);
    // timer was armed by the last push; flush must have cancelled it
    begin
      int seen = 0;
      for (int i = 0; i < 100; i++) begin
        tick();
        if (timeout) seen++;
      end
      chk("R8 timeout cancelled", seen, 0);
    end
  endtask

  task automatic t_timeout(logic [15:0] bc, logic [1:0] cl, logic p, logic s2,
                           int win, string tag);
    int early = 0;
    do_flush();
    bit_cycles = bc; char_len = cl; parity_en = p; two_stop = s2;
    tick();
    push(8'h99);
    for (int k = 1; k < win; k++) begin
      tick();
      if (timeout) early++;
    end
    chk({tag, " no early pulse"}, early, 0);
    tick();
    chk({tag, " pulse on time"}, timeout, 1);
    tick();
    chk({tag, " single pulse"}, timeout, 0);
    pop();
  endtask

  task automatic t_restart();
    int early = 0;
    do_flush();
    bit_cycles = 16'd1; char_len = 2'b00; parity_en = 1'b0; two_stop = 1'b0;
    push(8'h01);
    for (int k = 0; k < 20; k++) begin
      tick();
      if (timeout) early++;
    end
    push(8'h02);
    for (int k = 1; k < 32; k++) begin
      tick();
      if (timeout) early++;
    end
    chk("R10 restart no pulse", early, 0);
    tick();
    chk("R10 restart pulse", timeout, 1);
    do_flush();
  endtask

  initial begin
    rst = 1'b1; rx_en = 1'b1; flush = 1'b0; push_valid = 1'b0; push_data = '0;
    rd_strobe = 1'b0; lvl_we = 1'b0; lvl_wdata = '0;
    bit_cycles = 16'd2; char_len = 2'b10; parity_en = 1'b0; two_stop = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_order();
    t_overrun();
    t_simul();
    t_empty_read();
    t_disabled();
    t_trigger();
    t_flush();
    // 8N1, 2 cycles/bit: 10 bits -> 20 cycles/char -> 80
    t_timeout(16'd2, 2'b10, 1'b0, 1'b0, 80, "R10 8N1");
    // 7 bits + parity + 2 stop, 3 cycles/bit: 11 bits -> 33 -> 132
    t_timeout(16'd3, 2'b01, 1'b1, 1'b1, 132, "R10 7P2");
    // 6N1, 1 cycle/bit: 8 bits -> 8 -> 32
    t_timeout(16'd1, 2'b00, 1'b0, 1'b0, 32, "R10 6N1");
    t_restart();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule